// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the active-low read and write strobes for programmed-I/O data port transfers on one IDE channel, clocked by the bus clock. When a cycle request is accepted, the selected strobe goes low. It stays low for a programmable number of clocks, at which point the device ready line is first sampled. The strobe is released only once ready is seen high. A programmable minimum recovery interval, counted from that last ready sample, must then pass before the next strobe can begin.

The two timing values arrive as 2-bit codes. Each request picks one of two code pairs. The drive 1 pair, taken from an 8-bit timing register image, is used only when the request targets drive 1, addresses the data port, and has the channel's per-drive timing enable set. Every other request uses a default pair supplied on separate inputs. The register image holds code pairs for both channels, and a parameter tells the block which channel it serves.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is high and in the first cycle after it is released, both strobes are high (deasserted) and done is low.
- R2: With ready high, the strobe stays low for exactly 5, 4 or 3 clocks for sample-point codes 00, 01 and 10.
- R3: Sample-point code 11 gives the same 3-clock strobe as code 10.
- R4: With the request held high, the gap between strobe release and the next strobe assertion is 4, 3, 2 or 1 clocks for recovery codes 00, 01, 10 and 11.
- R5: When drive select is 1, the data-port flag is 1 and the per-drive enable is 1, the codes come from the register image. The secondary channel (SECONDARY=1) uses recovery in bits 7:6 and sample point in bits 5:4. The primary channel uses recovery in bits 3:2 and sample point in bits 1:0.
- R6: If any one of drive select, data-port flag or per-drive enable is 0, the default sample-point and recovery inputs are used.
- R7: If ready is low when the sample point is reached, the strobe stays low and ready is sampled on every clock. The strobe is released at the clock edge that first sees ready high.
- R8: done is high for exactly one clock, namely the first clock in which the strobe is high again.
- R9: Only one strobe is low at a time. Read (req_write=0) drives rd_n and write (req_write=1) drives wr_n. The direction is captured at acceptance, so later changes to req_write do not affect a cycle in progress.
- R10: The timing codes are captured at acceptance, so changing them during a strobe does not change its length.
- R11: No request is accepted while a strobe is active or recovery is still running, so a request that stays high during a strobe produces no extra strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Cycle request, level; accepted when the block is ready |
| req_write | input | 1 | Direction: 1 = write strobe, 0 = read strobe |
| drv_sel | input | 1 | Target drive: 1 = drive 1 |
| data_port | input | 1 | 1 when the access addresses the data port |
| drv1_tim_en | input | 1 | Channel per-drive timing enable |
| drv1_timing | input | REG_W | Drive 1 timing register image for both channels |
| dflt_sample | input | 2 | Default sample-point code |
| dflt_recov | input | 2 | Default recovery code |
| iordy | input | 1 | Device ready |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse when the strobe is released |

## Verification
The hardest case to reach from the ports is the minimum recovery gap. It shows up only when a second request is already waiting at the exact clock in which recovery expires, so an idle gap between requests would hide an off-by-one error. The bench therefore holds the request high across the end of the first strobe and counts the high clocks until the second strobe asserts, for each recovery code. For the ready-wait case it keeps ready low past the sample point and releases it at a chosen clock.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

    localparam int CODE_W = 2;
    localparam int CNT_W  = 3;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Recovery code in the upper half, so that one register nibble maps directly onto this struct
    typedef struct packed {
        code_t rec;
        code_t samp;
    } tim_fields_t;

    typedef struct packed {
        cnt_t samp_clks;
        cnt_t rec_clks;
    } tim_clks_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_RECOVER
    } seq_state_t;

    // Clocks from strobe assertion to the first ready sample; the reserved code behaves as 3
    function automatic cnt_t decode_sample(input code_t c);
        case (c)
            2'b00:   return cnt_t'(5);
            2'b01:   return cnt_t'(4);
            default: return cnt_t'(3);
        endcase
    endfunction

    // Minimum clocks from the last ready sample to the next strobe
    function automatic cnt_t decode_recovery(input code_t c);
        return cnt_t'(4) - cnt_t'(c);
    endfunction

endpackage

// File: rtl/pio_timing_select.sv
module pio_timing_select
    import pio_strobe_pkg::*;
#(
    parameter bit SECONDARY = 1'b0,
    parameter int REG_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drv_sel,
    input  logic              data_port,
    input  logic              drv1_en,
    input  logic [REG_W-1:0]  drv1_reg,
    input  tim_fields_t       dflt_fields,
    output tim_clks_t         clks
);
    localparam int NIB = $bits(tim_fields_t);

    tim_fields_t drv1_fields;
    tim_fields_t chosen;
    logic        use_drv1;
    logic        unused_other_nibble;

    generate
        if (SECONDARY) begin : g_sec
            assign drv1_fields         = drv1_reg[2*NIB-1:NIB];
            assign unused_other_nibble = ^drv1_reg[NIB-1:0];
        end else begin : g_pri
            assign drv1_fields         = drv1_reg[NIB-1:0];
            assign unused_other_nibble = ^drv1_reg[REG_W-1:NIB];
        end
    endgenerate

    assign use_drv1 = drv_sel && data_port && drv1_en;
    assign chosen   = use_drv1 ? drv1_fields : dflt_fields;

    assign clks.samp_clks = decode_sample(chosen.samp);
    assign clks.rec_clks  = decode_recovery(chosen.rec);

    // R2 R3: the sample delay stays within 3..5 clocks
    assert_sample_range_R2: assert property (@(posedge clk) disable iff (rst)
        (clks.samp_clks >= cnt_t'(3)) && (clks.samp_clks <= cnt_t'(5)));
    // R4: the recovery gap stays within 1..4 clocks
    assert_recovery_range_R4: assert property (@(posedge clk) disable iff (rst)
        (clks.rec_clks >= cnt_t'(1)) && (clks.rec_clks <= cnt_t'(4)));

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_strobe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       req_write,
    input  tim_clks_t  clks,
    input  logic       iordy,
    output logic       rd_n,
    output logic       wr_n,
    output logic       done
);
    seq_state_t state;
    cnt_t       cnt;
    cnt_t       rec_q;
    logic       wr_q;
    logic       ready;

    assign ready = (state == ST_IDLE) || ((state == ST_RECOVER) && (cnt == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            rec_q <= '0;
            wr_q  <= 1'b0;
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE, ST_RECOVER: begin
                    if (ready && req) begin
                        state <= ST_STROBE;
                        cnt   <= clks.samp_clks - cnt_t'(1);
                        rec_q <= clks.rec_clks;
                        wr_q  <= req_write;
                        rd_n  <= req_write;
                        wr_n  <= !req_write;
                    end else if (state == ST_RECOVER) begin
                        if (cnt == '0) state <= ST_IDLE;
                        else           cnt   <= cnt - cnt_t'(1);
                    end
                end
                ST_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - cnt_t'(1);
                    end else if (iordy) begin
                        rd_n  <= 1'b1;
                        wr_n  <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_RECOVER;
                        cnt   <= rec_q - cnt_t'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: never both strobes low
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    // R9: the active strobe follows the captured direction
    assert_dir_match_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STROBE) |-> (wr_q ? (!wr_n && rd_n) : (!rd_n && wr_n)));
    // R8: done is a single-clock pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: done coincides with the first clock after release
    assert_done_release_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n && wr_n) |-> done);
    // R7: ready low at the sample point keeps the strobe on
    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_STROBE) && (cnt == '0) && !iordy) |=> (state == ST_STROBE));
    // R11: a strobe only starts from a ready state
    assert_no_busy_accept_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n && wr_n) |-> $past(ready));

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_strobe_pkg::*;
#(
    parameter bit SECONDARY = 1'b0,
    parameter int REG_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_write,
    input  logic             drv_sel,
    input  logic             data_port,
    input  logic             drv1_tim_en,
    input  logic [REG_W-1:0] drv1_timing,
    input  logic [1:0]       dflt_sample,
    input  logic [1:0]       dflt_recov,
    input  logic             iordy,
    output logic             rd_n,
    output logic             wr_n,
    output logic             done
);
    tim_fields_t dflt;
    tim_clks_t   clks;

    assign dflt.samp = dflt_sample;
    assign dflt.rec  = dflt_recov;

    pio_timing_select #(.SECONDARY(SECONDARY), .REG_W(REG_W)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .drv_sel     (drv_sel),
        .data_port   (data_port),
        .drv1_en     (drv1_tim_en),
        .drv1_reg    (drv1_timing),
        .dflt_fields (dflt),
        .clks        (clks)
    );

    pio_strobe_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_write (req_write),
        .clks      (clks),
        .iordy     (iordy),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .done      (done)
    );

endmodule

// File: tb/pio_strobe_gen_test.sv
`timescale 1ns/1ps
module pio_strobe_gen_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, wr = 1'b0, dsel = 1'b0, dport = 1'b0, en = 1'b0, iordy = 1'b1;
    logic [7:0] dreg = 8'h00;
    logic [1:0] dsamp = 2'b00, drec = 2'b00;
    logic rd_n, wr_n, done, rd2_n, wr2_n, done2;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pio_strobe_gen #(.SECONDARY(1'b0)) uut (
        .clk(clk), .rst(rst), .req(req), .req_write(wr), .drv_sel(dsel),
        .data_port(dport), .drv1_tim_en(en), .drv1_timing(dreg),
        .dflt_sample(dsamp), .dflt_recov(drec), .iordy(iordy),
        .rd_n(rd_n), .wr_n(wr_n), .done(done));

    pio_strobe_gen #(.SECONDARY(1'b1)) uut_sec (
        .clk(clk), .rst(rst), .req(req), .req_write(wr), .drv_sel(dsel),
        .data_port(dport), .drv1_tim_en(en), .drv1_timing(dreg),
        .dflt_sample(dsamp), .dflt_recov(drec), .iordy(iordy),
        .rd_n(rd2_n), .wr_n(wr2_n), .done(done2));

    function automatic logic strb(input bit sec, input bit w);
        if (sec) return w ? wr2_n : rd2_n;
        return w ? wr_n : rd_n;
    endfunction

    function automatic logic dn(input bit sec);
        return sec ? done2 : done;
    endfunction

    function automatic int exp_samp(input logic [1:0] c);
        case (c)
            2'b00: return 5;
            2'b01: return 4;
            default: return 3;
        endcase
    endfunction

    function automatic int exp_rec(input logic [1:0] c);
        case (c)
            2'b00: return 4;
            2'b01: return 3;
            2'b10: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One strobe plus the recovery gap to a second, back-to-back strobe
    task automatic measure(input bit sec, input bit w, output int lo, output int gap,
                           output bit done_ok, output bit other_ok);
        int guard;
        lo = 0; gap = 0; done_ok = 1'b1; other_ok = 1'b1; guard = 0;
        @(negedge clk); wr = w; req = 1'b1;
        @(negedge clk);
        while (strb(sec, w) && guard < 30) begin guard++; @(negedge clk); end
        while (!strb(sec, w) && lo < 40) begin
            lo++;
            if (!strb(sec, !w)) other_ok = 1'b0;
            @(negedge clk);
        end
        if (!dn(sec)) done_ok = 1'b0;
        while (strb(sec, w) && gap < 40) begin
            gap++;
            @(negedge clk);
            if (gap == 1 && dn(sec)) done_ok = 1'b0;
        end
        req = 1'b0;
        while (!strb(sec, w) && guard < 80) begin guard++; @(negedge clk); end
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 rd_n in reset", rd_n, 1);
        chk("R1 wr_n in reset", wr_n, 1);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_n after reset", rd_n, 1);
        chk("R1 wr_n after reset", wr_n, 1);
        chk("R1 done after reset", done, 0);
    endtask

    task automatic t_codes;
        int lo, gap; bit d_ok, o_ok;
        dsel = 1'b0;
        for (int c = 0; c < 4; c++) begin
            dsamp = 2'(c); drec = 2'(c);
            measure(1'b0, c[0], lo, gap, d_ok, o_ok);
            if (c == 3) chk("R3 reserved sample code width", lo, 3);
            else        chk("R2 sample code width", lo, exp_samp(2'(c)));
            chk("R4 recovery gap", gap, exp_rec(2'(c)));
            chk("R8 done single pulse at release", d_ok, 1);
            chk("R9 other strobe idle", o_ok, 1);
        end
    endtask

    task automatic t_drive1;
        int lo, gap; bit d_ok, o_ok;
        // secondary: rec 11 samp 10; primary: rec 01 samp 00
        dreg = {2'b11, 2'b10, 2'b01, 2'b00};
        dsamp = 2'b01; drec = 2'b10;
        dsel = 1'b1; dport = 1'b1; en = 1'b1;
        measure(1'b0, 1'b0, lo, gap, d_ok, o_ok);
        chk("R5 primary drive1 width", lo, 5);
        chk("R5 primary drive1 gap", gap, 3);
        measure(1'b1, 1'b1, lo, gap, d_ok, o_ok);
        chk("R5 secondary drive1 width", lo, 3);
        chk("R5 secondary drive1 gap", gap, 1);
    endtask

    task automatic t_defaults;
        int lo, gap; bit d_ok, o_ok;
        for (int k = 0; k < 3; k++) begin
            dsel = (k != 0); dport = (k != 1); en = (k != 2);
            measure(1'b0, 1'b1, lo, gap, d_ok, o_ok);
            chk("R6 default width", lo, 4);
            chk("R6 default gap", gap, 2);
        end
        dsel = 1'b0; dport = 1'b0; en = 1'b0;
    endtask

    task automatic t_iordy_wait;
        int lo;
        dsamp = 2'b10; drec = 2'b11; iordy = 1'b0; lo = 0;
        @(negedge clk); wr = 1'b0; req = 1'b1;
        @(negedge clk); req = 1'b0;
        while (!rd_n && lo < 40) begin
            lo++;
            if (lo == 6) iordy = 1'b1;
            @(negedge clk);
        end
        chk("R7 strobe held until ready", lo, 6);
        chk("R8 done after ready wait", done, 1);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_direction;
        int rd_lo, wr_lo;
        dsamp = 2'b01; rd_lo = 0; wr_lo = 0;
        @(negedge clk); wr = 1'b0; req = 1'b1;
        @(negedge clk); wr = 1'b1; req = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (!rd_n) rd_lo++;
            if (!wr_n) wr_lo++;
            @(negedge clk);
        end
        chk("R9 read strobe kept after direction change", rd_lo, 4);
        chk("R9 write strobe stays idle", wr_lo, 0);
    endtask

    task automatic t_latch;
        int lo;
        dsamp = 2'b00; lo = 0;
        @(negedge clk); wr = 1'b1; req = 1'b1;
        @(negedge clk); req = 1'b0; dsamp = 2'b10;
        while (!wr_n && lo < 40) begin lo++; @(negedge clk); end
        chk("R10 width fixed at acceptance", lo, 5);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_busy;
        int starts; logic prev;
        dsamp = 2'b00; drec = 2'b00; starts = 0; prev = 1'b1;
        @(negedge clk); wr = 1'b0; req = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (prev && !rd_n) starts++;
            prev = rd_n;
        end
        req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (prev && !rd_n) starts++;
            prev = rd_n;
        end
        chk("R11 one strobe while busy", starts, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_codes();
        t_drive1();
        t_defaults();
        t_iordy_wait();
        t_direction();
        t_latch();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule